// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block is a synthesizable model of a synchronous static RAM whose data bus never needs an idle cycle when traffic turns from reads to writes. Each command (address, read/write select, byte enables, three chip selects, burst advance) is captured on the rising clock edge. The data for a write arrives on the write-data port a fixed number of cycles after its command. Read data leaves on the read port after the same number of cycles. Because the write-data port and the read port are both busy on every cycle, a stream such as read, write, read runs at full rate.

A static mode pin picks one of two timings. In flow-through mode the latency is one cycle for both read data and write data. In pipelined mode an output register adds a second cycle, and write data is taken two cycles after its command. Writes whose data has not yet landed are tracked in a short command pipe. A read of such an address is served with the pending bytes merged in. Each 9-bit byte lane holds eight data bits and one parity bit. Parity is checked on every enabled lane when the data is written. A four-beat burst can be continued without a new address, in linear or interleaved order. An asynchronous output enable gates the bus drive flag, and a sleep input blocks new commands.

Top module: `nbt_sram_core`

## Requirements
- R1: After synchronous reset, rvalid, dq_oe and par_err are all 0 and no burst is active.
- R2: A new command is accepted only when ce_a=1, ce_b=1 and ce_n=0 with adv=0. Any other chip-select combination with adv=0 is a deselect: it produces no read result and no write, and it ends the current burst.
- R3: With pipe_mode=0, a read accepted at clock edge T shows rvalid=1 and its data on rdata after edge T+1.
- R4: With pipe_mode=1, a read accepted at edge T shows rvalid=1 and its data after edge T+2.
- R5: The data for a write accepted at edge T is sampled from wdata at edge T+1 when pipe_mode=0, and at edge T+2 when pipe_mode=1.
- R6: Byte lane i is wdata/rdata bits [9i+8:9i], with bit 9i+8 as the parity bit. A write stores only the lanes whose byte_en bit is 1 and leaves every other lane of the word unchanged.
- R7: A read returns the effect of every write accepted before it, including a write whose late data has not yet been stored, with that write's enabled lanes merged over the stored word.
- R8: Reads and writes may be accepted on consecutive edges in any mix, with no idle cycle between them.
- R9: With odd_par=0 a lane is correct when the XOR of its 9 bits is 0; with odd_par=1, when it is 1. par_err[i] is 1 for exactly the cycle after the edge that samples a write's data, if lane i is enabled and incorrect. The write is still stored.
- R10: adv=1 during an active burst issues the next beat, of the same kind (read or write) as the burst's first command. The low two address bits of beat n are (base+n) mod 4 when burst_ilv=0, or base XOR n when burst_ilv=1, where n wraps modulo 4. The upper address bits stay those of the first command. Chip selects are not examined on an advance.
- R11: adv=1 while no burst is active is ignored: no read result and no write.
- R12: dq_oe equals oe AND rvalid combinationally, so oe=0 turns the drive flag off at once without disturbing the read pipeline.
- R13: While sleep=1, the command on the pins is ignored and the burst state is kept. Commands already in flight still complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| pipe_mode | input | 1 | Static timing mode: 1 pipelined, 0 flow-through |
| burst_ilv | input | 1 | Static burst order: 1 interleaved, 0 linear |
| odd_par | input | 1 | Static parity sense: 1 odd, 0 even |
| sleep | input | 1 | Blocks acceptance of new commands |
| ce_a | input | 1 | Chip select, active high |
| ce_b | input | 1 | Chip select, active high |
| ce_n | input | 1 | Chip select, active low |
| adv | input | 1 | Continue the current burst |
| we | input | 1 | 1 write, 0 read for a new command |
| byte_en | input | NBYTES | Per-lane write enable |
| addr | input | ADDR_W | Word address of a new command |
| wdata | input | 9*NBYTES | Late write data, lanes as in R6 |
| oe | input | 1 | Asynchronous output enable |
| rdata | output | 9*NBYTES | Read data |
| rvalid | output | 1 | rdata holds a read result |
| dq_oe | output | 1 | Bus drive enable |
| par_err | output | NBYTES | Per-lane write parity error |

## Verification
A wrong command-pipe entry shows up as a read result at the wrong cycle, or as data that lacks a recent write. This becomes visible two to three cycles after the faulty command, when the bench compares rvalid and rdata against a command-order memory model. A bad forwarding path only shows on a pipelined read that directly follows a write to the same word, so directed back-to-back sequences target it. Burst counter errors show as data from the wrong word on the beat after the bad step. Parity faults appear on par_err one cycle after the data edge.

// File: rtl/nbt_pkg.sv
package nbt_pkg;
  localparam int LANE_W = 9;

  function automatic logic [1:0] burst_low(input logic [1:0] base, input logic [1:0] cnt,
                                           input logic ilv);
    return ilv ? (base ^ cnt) : (base + cnt);
  endfunction

  function automatic logic lane_bad(input logic [LANE_W-1:0] lane, input logic odd);
    return (^lane) != odd;
  endfunction
endpackage

// File: rtl/nbt_cmd_ctrl.sv
module nbt_cmd_ctrl #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pipe_mode,
  input  logic              burst_ilv,
  input  logic              sleep,
  input  logic              ce_a,
  input  logic              ce_b,
  input  logic              ce_n,
  input  logic              adv,
  input  logic              we,
  input  logic [NBYTES-1:0] byte_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              c1_v,
  output logic              c1_we,
  output logic [ADDR_W-1:0] c1_addr,
  output logic              wr_v,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [NBYTES-1:0] wr_be
);
  import nbt_pkg::*;

  logic              sel, adv_go, new_go, iss_v, iss_we;
  logic [ADDR_W-1:0] iss_addr;
  logic              b_act, b_we;
  logic [ADDR_W-1:0] b_base;
  logic [1:0]        b_cnt, nxt_cnt;
  logic [NBYTES-1:0] c1_be, c2_be;
  logic              c2_v, c2_we;
  logic [ADDR_W-1:0] c2_addr;

  assign sel     = ce_a & ce_b & ~ce_n;
  assign adv_go  = adv & b_act;
  assign new_go  = ~adv & sel;
  assign iss_v   = ~sleep & (adv_go | new_go);
  assign nxt_cnt = b_cnt + 2'd1;
  assign iss_we  = adv ? b_we : we;
  assign iss_addr = adv ? {b_base[ADDR_W-1:2], burst_low(b_base[1:0], nxt_cnt, burst_ilv)}
                        : addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      b_act  <= 1'b0;
      b_we   <= 1'b0;
      b_base <= '0;
      b_cnt  <= 2'd0;
    end else if (!sleep) begin
      if (new_go) begin
        b_act  <= 1'b1;
        b_we   <= we;
        b_base <= addr;
        b_cnt  <= 2'd0;
      end else if (adv_go) begin
        b_cnt  <= nxt_cnt;
      end else if (!adv) begin
        b_act  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c1_v <= 1'b0; c1_we <= 1'b0; c1_addr <= '0; c1_be <= '0;
      c2_v <= 1'b0; c2_we <= 1'b0; c2_addr <= '0; c2_be <= '0;
    end else begin
      c1_v    <= iss_v;
      c1_we   <= iss_we;
      c1_addr <= iss_addr;
      c1_be   <= byte_en;
      c2_v    <= c1_v;
      c2_we   <= c1_we;
      c2_addr <= c1_addr;
      c2_be   <= c1_be;
    end
  end

  // late-write commit stage: depth 1 in flow-through, depth 2 in pipelined mode
  assign wr_v    = pipe_mode ? (c2_v & c2_we) : (c1_v & c1_we);
  assign wr_addr = pipe_mode ? c2_addr : c1_addr;
  assign wr_be   = pipe_mode ? c2_be : c1_be;

  AST_SLEEP_IDLE: assert property (@(posedge clk) disable iff (rst) sleep |=> !c1_v); // R13
  AST_ADV_STEP: assert property (@(posedge clk) disable iff (rst)
    (!sleep && adv && b_act) |=> (b_cnt == $past(b_cnt) + 2'd1)); // R10
  AST_NO_ADV_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!sleep && adv && !b_act) |=> !c1_v); // R11
  AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!sleep && !adv && !(ce_a && ce_b && !ce_n)) |=> (!c1_v && !b_act)); // R2
endmodule

// File: rtl/nbt_array.sv
module nbt_array #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 2,
  localparam int LW    = nbt_pkg::LANE_W,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int DW    = NBYTES * LW
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NBYTES-1:0] wr_be,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_q
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    logic [LW-1:0] q;
    always_ff @(posedge clk) begin
      if (wr_en && wr_be[i]) mem[wr_addr] <= wr_data[i*LW +: LW];
      if (rd_en) q <= mem[rd_addr];
    end
    assign rd_q[i*LW +: LW] = q;
  end
endmodule

// File: rtl/nbt_par_chk.sv
module nbt_par_chk #(
  parameter int NBYTES = 2,
  localparam int LW = nbt_pkg::LANE_W,
  localparam int DW = NBYTES * LW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              odd_par,
  input  logic              chk_en,
  input  logic [NBYTES-1:0] be,
  input  logic [DW-1:0]     data,
  output logic [NBYTES-1:0] par_err
);
  import nbt_pkg::*;

  for (genvar i = 0; i < NBYTES; i++) begin : g_chk
    always_ff @(posedge clk) begin
      if (rst) par_err[i] <= 1'b0;
      else     par_err[i] <= chk_en & be[i] & lane_bad(data[i*LW +: LW], odd_par);
    end
  end

  AST_ERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    (|par_err) |-> $past(chk_en)); // R9
endmodule

// File: rtl/nbt_rd_path.sv
module nbt_rd_path #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 2,
  localparam int LW = nbt_pkg::LANE_W,
  localparam int DW = NBYTES * LW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pipe_mode,
  input  logic              oe,
  input  logic              c1_v,
  input  logic              c1_we,
  input  logic [ADDR_W-1:0] c1_addr,
  input  logic              wr_v,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NBYTES-1:0] wr_be,
  input  logic [DW-1:0]     wr_data,
  input  logic [DW-1:0]     mem_q,
  output logic [DW-1:0]     rdata,
  output logic              rvalid,
  output logic              dq_oe
);
  logic              c1_rd, same_word, rv1, rv2;
  logic [NBYTES-1:0] fwd_hit;
  logic [DW-1:0]     fwd_d, merged, out_q;

  assign c1_rd     = c1_v & ~c1_we;
  assign same_word = wr_v & (wr_addr == c1_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      rv1 <= 1'b0; rv2 <= 1'b0; fwd_hit <= '0; fwd_d <= '0; out_q <= '0;
    end else begin
      rv1     <= c1_rd;
      rv2     <= rv1;
      fwd_hit <= (c1_rd && same_word) ? wr_be : '0;
      fwd_d   <= wr_data;
      out_q   <= merged;
    end
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_merge
    assign merged[i*LW +: LW] = fwd_hit[i] ? fwd_d[i*LW +: LW] : mem_q[i*LW +: LW];
  end

  assign rvalid = pipe_mode ? rv2 : rv1;
  assign rdata  = pipe_mode ? out_q : merged;
  assign dq_oe  = oe & rvalid;

  AST_PIPE_LAT: assert property (@(posedge clk) disable iff (rst)
    (pipe_mode && rv1) |=> rvalid); // R4
  AST_FLOW_LAT: assert property (@(posedge clk) disable iff (rst)
    (!pipe_mode && c1_v && !c1_we) |=> rvalid); // R3
endmodule

// File: rtl/nbt_sram_core.sv
module nbt_sram_core #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 2,
  localparam int DW = NBYTES * nbt_pkg::LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pipe_mode,
  input  logic              burst_ilv,
  input  logic              odd_par,
  input  logic              sleep,
  input  logic              ce_a,
  input  logic              ce_b,
  input  logic              ce_n,
  input  logic              adv,
  input  logic              we,
  input  logic [NBYTES-1:0] byte_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic              oe,
  output logic [DW-1:0]     rdata,
  output logic              rvalid,
  output logic              dq_oe,
  output logic [NBYTES-1:0] par_err
);
  logic              c1_v, c1_we, wr_v;
  logic [ADDR_W-1:0] c1_addr, wr_addr;
  logic [NBYTES-1:0] wr_be;
  logic [DW-1:0]     mem_q;

  nbt_cmd_ctrl #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_ctrl (
    .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .burst_ilv(burst_ilv), .sleep(sleep),
    .ce_a(ce_a), .ce_b(ce_b), .ce_n(ce_n), .adv(adv), .we(we), .byte_en(byte_en),
    .addr(addr), .c1_v(c1_v), .c1_we(c1_we), .c1_addr(c1_addr), .wr_v(wr_v),
    .wr_addr(wr_addr), .wr_be(wr_be)
  );

  nbt_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_array (
    .clk(clk), .wr_en(wr_v), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wdata),
    .rd_en(c1_v & ~c1_we), .rd_addr(c1_addr), .rd_q(mem_q)
  );

  nbt_par_chk #(.NBYTES(NBYTES)) u_par (
    .clk(clk), .rst(rst), .odd_par(odd_par), .chk_en(wr_v), .be(wr_be), .data(wdata),
    .par_err(par_err)
  );

  nbt_rd_path #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_rd (
    .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .oe(oe), .c1_v(c1_v), .c1_we(c1_we),
    .c1_addr(c1_addr), .wr_v(wr_v), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wdata),
    .mem_q(mem_q), .rdata(rdata), .rvalid(rvalid), .dq_oe(dq_oe)
  );
endmodule

// File: tb/sim_nbt_sram_core.sv
`timescale 1ns/1ps
module sim_nbt_sram_core;
  localparam int AW = 6;
  localparam int NB = 2;
  localparam int DW = NB * 9;
  localparam int NCYC = 8192;

  logic clk = 1'b0;
  logic rst = 1'b1, pipe_mode = 1'b0, burst_ilv = 1'b0, odd_par = 1'b0, sleep = 1'b0;
  logic ce_a = 1'b0, ce_b = 1'b0, ce_n = 1'b1, adv = 1'b0, we = 1'b0, oe = 1'b1;
  logic [NB-1:0] byte_en = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rvalid, dq_oe;
  logic [NB-1:0] par_err;

  always #2.5 clk = ~clk;

  nbt_sram_core #(.ADDR_W(AW), .NBYTES(NB)) u0 (
    .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .burst_ilv(burst_ilv), .odd_par(odd_par),
    .sleep(sleep), .ce_a(ce_a), .ce_b(ce_b), .ce_n(ce_n), .adv(adv), .we(we),
    .byte_en(byte_en), .addr(addr), .wdata(wdata), .oe(oe), .rdata(rdata),
    .rvalid(rvalid), .dq_oe(dq_oe), .par_err(par_err)
  );

  int nchk = 0, nfail = 0, cyc = 0, lat = 1;
  bit done = 0;
  string cur_tag = "";
  logic [DW-1:0] refm [1 << AW];
  bit            exp_rv [NCYC];
  logic [DW-1:0] exp_rd [NCYC];
  logic [NB-1:0] exp_pe [NCYC];
  string         exp_tag [NCYC];
  bit            wd_v [NCYC];
  logic [DW-1:0] wd [NCYC];
  bit            b_act = 0, b_we = 0;
  logic [AW-1:0] b_base = '0;
  logic [1:0]    b_cnt = 2'd0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] make_data(logic [NB-1:0] bad);
    logic [DW-1:0] v;
    for (int i = 0; i < NB; i++) begin
      logic [31:0] r;
      logic [7:0] d;
      r = $urandom;
      d = r[7:0];
      v[i*9 +: 9] = {(^d) ^ odd_par ^ bad[i], d};
    end
    return v;
  endfunction

  task automatic check_outputs();
    string t;
    t = exp_rv[cyc] ? exp_tag[cyc] : (cur_tag != "" ? cur_tag : "R2");
    chk(t, 32'(rvalid), 32'(exp_rv[cyc]));
    if (exp_rv[cyc]) chk(t, 32'(rdata), 32'(exp_rd[cyc]));
    chk(cur_tag != "" ? cur_tag : "R9", 32'(par_err), 32'(exp_pe[cyc]));
    chk(cur_tag != "" ? cur_tag : "R12", 32'(dq_oe), 32'(oe & exp_rv[cyc]));
  endtask

  task automatic model(bit s, bit a, bit [2:0] ce, bit w, logic [AW-1:0] ad,
                       logic [NB-1:0] be, logic [NB-1:0] badp);
    bit iv = 0, iw = 0;
    logic [AW-1:0] ia = '0;
    string tg;
    tg = (cur_tag != "") ? cur_tag : (lat == 2 ? "R4" : "R3");
    if (s) return;
    if (a) begin
      if (b_act) begin
        b_cnt = b_cnt + 2'd1;
        ia = {b_base[AW-1:2], burst_ilv ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt)};
        iw = b_we; iv = 1;
        if (cur_tag == "") tg = "R10";
      end
    end else if (ce == 3'b110) begin
      b_act = 1; b_we = w; b_base = ad; b_cnt = 2'd0;
      ia = ad; iw = w; iv = 1;
    end else begin
      b_act = 0;
    end
    if (!iv) return;
    if (iw) begin
      logic [DW-1:0] d;
      d = make_data(badp);
      for (int i = 0; i < NB; i++) if (be[i]) refm[ia][i*9 +: 9] = d[i*9 +: 9];
      wd[cyc + lat] = d; wd_v[cyc + lat] = 1;
      exp_pe[cyc + lat + 1] = be & badp;
    end else begin
      exp_rv[cyc + lat + 1] = 1;
      exp_rd[cyc + lat + 1] = refm[ia];
      exp_tag[cyc + lat + 1] = tg;
    end
  endtask

  task automatic do_cycle(bit s, bit a, bit [2:0] ce, bit w, logic [AW-1:0] ad,
                          logic [NB-1:0] be, logic [NB-1:0] badp);
    logic [31:0] r;
    @(negedge clk);
    check_outputs();
    rst = 0; sleep = s; adv = a; ce_a = ce[2]; ce_b = ce[1]; ce_n = ce[0];
    we = w; addr = ad; byte_en = be;
    oe = ($urandom % 4) != 0;
    r = $urandom;
    wdata = wd_v[cyc] ? wd[cyc] : r[DW-1:0];
    model(s, a, ce, w, ad, be, badp);
    cyc++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) do_cycle(0, 0, 3'b000, 0, '0, '0, '0);
  endtask
  task automatic rd(logic [AW-1:0] ad);
    do_cycle(0, 0, 3'b110, 0, ad, '0, '0);
  endtask
  task automatic wr(logic [AW-1:0] ad, logic [NB-1:0] be, logic [NB-1:0] badp);
    do_cycle(0, 0, 3'b110, 1, ad, be, badp);
  endtask
  task automatic advc();
    do_cycle(0, 1, 3'b000, 0, '0, '1, '0);
  endtask

  task automatic do_reset(bit pm, bit il, bit op);
    @(negedge clk);
    rst = 1; pipe_mode = pm; burst_ilv = il; odd_par = op; sleep = 0; adv = 0;
    ce_a = 0; ce_b = 0; ce_n = 1; we = 0; oe = 1; cyc++;
    @(negedge clk); cyc++;
    b_act = 0; b_cnt = 2'd0; lat = pm ? 2 : 1;
    cur_tag = "R1";
    do_cycle(0, 0, 3'b000, 0, '0, '0, '0);
    cur_tag = "";
  endtask

  task automatic rand_phase(int n);
    for (int k = 0; k < n; k++) begin
      int r;
      logic [AW-1:0] ad;
      logic [NB-1:0] be, bp;
      logic [31:0] x;
      r = $urandom % 100;
      x = $urandom;
      ad = (x[31:30] != 0) ? {3'b000, x[2:0]} : x[AW-1:0];
      be = x[9:8]; if (be == 0) be = '1;
      bp = (x[15:12] == 0) ? x[17:16] : '0;
      if (r < 35)      rd(ad);
      else if (r < 70) wr(ad, be, bp);
      else if (r < 82) do_cycle(0, 1, x[22:20], x[23], ad, be, bp);
      else if (r < 90) do_cycle(0, 0, (x[22:20] == 3'b110) ? 3'b111 : x[22:20], x[23], ad, be, bp);
      else if (r < 95) do_cycle(1, x[24], x[22:20], x[23], ad, be, bp);
      else             idle(1);
    end
    idle(4);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL R8 watchdog: actual=running expected=finished");
      report();
    end
  end

  initial begin
    process p;
    p = process::self();
    p.srandom(32'h5eed_1234);
    for (int i = 0; i < NCYC; i++) begin
      exp_rv[i] = 0; exp_rd[i] = '0; exp_pe[i] = '0; exp_tag[i] = ""; wd_v[i] = 0; wd[i] = '0;
    end

    // flow-through, linear, even parity; fill every word (R5)
    do_reset(0, 0, 0);
    cur_tag = "R5";
    for (int a = 0; a < (1 << AW); a++) wr(a[AW-1:0], '1, '0);
    for (int a = 0; a < 8; a++) rd(a[AW-1:0]);
    cur_tag = "R3"; wr(6'd40, '1, '0); rd(6'd40); rd(6'd41);
    cur_tag = "R10"; do_cycle(0, 0, 3'b110, 0, 6'd22, '0, '0); advc(); advc(); advc(); advc();
    idle(4);
    cur_tag = "";
    rand_phase(400);

    // pipelined, linear, even parity
    do_reset(1, 0, 0);
    cur_tag = "R7"; wr(6'd5, 2'b11, '0); rd(6'd5); wr(6'd5, 2'b01, '0); rd(6'd5); rd(6'd5);
    cur_tag = "R8"; rd(6'd6); wr(6'd6, 2'b11, '0); rd(6'd6); wr(6'd7, 2'b10, '0); rd(6'd7);
    cur_tag = "R6"; wr(6'd9, 2'b01, '0); idle(1); rd(6'd9); wr(6'd9, 2'b10, '0); rd(6'd9);
    cur_tag = "R9"; wr(6'd10, 2'b11, 2'b10); wr(6'd11, 2'b01, 2'b11); rd(6'd10);
    cur_tag = "R10"; wr(6'd21, 2'b11, '0); advc(); advc(); advc();
    rd(6'd21); advc(); advc(); advc(); advc();
    cur_tag = "R11"; idle(1); advc(); advc(); rd(6'd3); idle(1); advc();
    cur_tag = "R13"; do_cycle(1, 0, 3'b110, 0, 6'd4, '0, '0);
    rd(6'd12); do_cycle(1, 1, 3'b000, 0, '0, '0, '0); advc();
    do_cycle(1, 0, 3'b110, 1, 6'd12, 2'b11, '0); rd(6'd12);
    cur_tag = "R2"; do_cycle(0, 0, 3'b010, 0, 6'd1, '0, '0); do_cycle(0, 0, 3'b100, 0, 6'd1, '0, '0);
    do_cycle(0, 0, 3'b111, 1, 6'd1, 2'b11, '0); rd(6'd1);
    idle(4);
    cur_tag = "";
    rand_phase(400);

    // pipelined, interleaved, odd parity
    do_reset(1, 1, 1);
    cur_tag = "R10"; do_cycle(0, 0, 3'b110, 0, 6'd27, '0, '0); advc(); advc(); advc(); advc();
    cur_tag = "R9"; wr(6'd30, 2'b11, 2'b01); rd(6'd30);
    idle(4);
    cur_tag = "";
    rand_phase(400);

    // flow-through, interleaved, odd parity
    do_reset(0, 1, 1);
    cur_tag = "R10"; wr(6'd46, 2'b11, '0); advc(); advc(); advc();
    rd(6'd46); advc(); advc(); advc();
    cur_tag = "R12"; rd(6'd2); rd(6'd2); rd(6'd2);
    idle(4);
    cur_tag = "";
    rand_phase(400);

    done = 1;
    report();
  end
endmodule